// File: doc/BRIEF.md
# Fair Hit-Merge Arbiter with Pulse Width

This block gathers pending time measurements from a bank of channel buffers and turns them into one write stream toward a shared hit store. Every channel raises a request line that is asynchronous to the arbiter clock and holds a leading-edge and a trailing-edge time on its data lines. The arbiter grants at most one channel per clock. For the granted channel it writes one combined entry: the channel number, the leading-edge time as it was presented, and an 8-bit pulse width.

Fairness comes from an active queue. When the queue is empty, the arbiter takes a snapshot of every request that is pending. It serves the snapshot lowest channel first. It ignores new arrivals until the snapshot is fully drained. The width is the trailing time minus the leading time. The subtraction wraps at a programmed counter roll-over value. The result is scaled by a 3-bit resolution code and clamps at the top of its 8-bit range.

A channel keeps its request asserted until it sees its grant pulse, then drops the request. The arbiter does not serve that channel again until the synchronized request has been seen low.

The control is a two-state machine:
- State `ST_IDLE` means the queue is empty.
- State `ST_SERVE` means snapshot entries remain.
- Transition *load*: `ST_IDLE` to `ST_SERVE` when a snapshot holds two or more requests.
- Transition *load-single*: `ST_IDLE` stays in `ST_IDLE` when the snapshot holds exactly one request.
- Transition *drain*: `ST_SERVE` stays in `ST_SERVE` while entries are left after the current grant.
- Transition *empty*: `ST_SERVE` to `ST_IDLE` on the grant of the last entry.

Top module: `hm_merge_arb`

## Requirements
- R1: After reset, `gnt` is all zeros and `wr_en` is 0 until a request has passed the synchronizer.
- R2: Each request passes through two flip-flops. A request driven between two rising edges produces its write, with `wr_en` high, after the third rising edge that follows. It produces no write after the second.
- R3: The snapshot is served in ascending channel-number order. Channel 0 has the highest priority.
- R4: Requests that arrive while the queue holds entries are served only after every entry of the current snapshot. When the queue is empty, the snapshot is taken in the same cycle as the first grant from it.
- R5: At most one bit of `gnt` is high in any cycle. A grant pulse lasts one cycle and coincides with `wr_en`, with `wr_ch` equal to the index of the high `gnt` bit.
- R6: A request that stays high after its grant gives exactly one write. The channel is eligible again only once its synchronized request has been low.
- R7: `wr_lead` equals the granted channel's leading time, unmodified.
- R8: The raw width is trail − lead when trail ≥ lead, and trail + `roll_max` + 1 − lead otherwise. This corresponds to a time counter that counts 0..`roll_max` and then wraps to 0.
- R9: `wsel` = k drops the k low bits of the raw width (a right shift by k, for k in 0..7).
- R10: If the shifted width exceeds 255, `wr_width` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_req | input | NCH | Asynchronous per-channel request levels |
| ch_lead | input | NCH*TW | Leading time of each channel, channel i at bits [i*TW +: TW] |
| ch_trail | input | NCH*TW | Trailing time of each channel, same packing |
| roll_max | input | TW | Last value of the time counter before it wraps |
| wsel | input | 3 | Width resolution code (number of low bits dropped) |
| gnt | output | NCH | One-cycle grant pulse per channel |
| wr_en | output | 1 | Write strobe of the combined entry |
| wr_ch | output | CHW | Granted channel number |
| wr_lead | output | TW | Leading-edge time of the entry |
| wr_width | output | 8 | Scaled, saturated pulse width |

## Verification
The embedded assertions watch on every cycle that grants stay one-hot and never repeat for a channel on consecutive cycles. They also check that a write always names a granted channel and that the queue only loses bits while it is draining.

Properties that span a whole scenario can only be shown by the directed tests. These are:
- the exact three-edge synchronizer latency;
- the ascending order of a snapshot;
- the exclusion of late arrivals until the drain completes;
- the single service of a held request;
- the numeric width across roll-over wrap, every resolution code and saturation.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } arb_state_t;

endpackage

// File: rtl/hm_sync.sv
module hm_sync #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/hm_prio.sv
module hm_prio #(
    parameter int N   = 24,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   vec,
    output logic           found,
    output logic [IDW-1:0] idx,
    output logic [N-1:0]   onehot
);

    always_comb begin
        idx = '0;
        // Scan from the top down so that the lowest set bit is kept.
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDW'(i);
        end
    end

    assign found = |vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_oh
            assign onehot[g] = found && (idx == IDW'(g));
        end
    endgenerate

endmodule

// File: rtl/hm_width.sv
module hm_width #(
    parameter int TW = 13
) (
    input  logic [TW-1:0] lead,
    input  logic [TW-1:0] trail,
    input  logic [TW-1:0] roll,
    input  logic [2:0]    sel,
    output logic [7:0]    width
);

    localparam int EW = TW + 1;

    logic [EW-1:0] raw;
    logic [EW-1:0] shifted;

    always_comb begin
        if (trail >= lead) begin
            raw = {1'b0, trail} - {1'b0, lead};
        end else begin
            raw = {1'b0, trail} + {1'b0, roll} + EW'(1) - {1'b0, lead};
        end
        shifted = raw >> sel;
        if (|shifted[EW-1:8]) begin
            width = 8'hFF;
        end else begin
            width = shifted[7:0];
        end
    end

endmodule

// File: rtl/hm_merge_arb.sv
module hm_merge_arb
    import hm_pkg::*;
#(
    parameter int NCH = 24,
    parameter int TW  = 13,
    parameter int CHW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     ch_req,
    input  logic [NCH*TW-1:0]  ch_lead,
    input  logic [NCH*TW-1:0]  ch_trail,
    input  logic [TW-1:0]      roll_max,
    input  logic [2:0]         wsel,
    output logic [NCH-1:0]     gnt,
    output logic               wr_en,
    output logic [CHW-1:0]     wr_ch,
    output logic [TW-1:0]      wr_lead,
    output logic [7:0]         wr_width
);

    arb_state_t     state_q, state_d;
    logic [NCH-1:0] sreq;
    logic [NCH-1:0] ok_q, ok_d;
    logic [NCH-1:0] queue_q, queue_d;
    logic [NCH-1:0] avail;
    logic [NCH-1:0] pick_src;
    logic           pick_found;
    logic [CHW-1:0] pick_idx;
    logic [NCH-1:0] pick_oh;
    logic [TW-1:0]  sel_lead;
    logic [TW-1:0]  sel_trail;
    logic [7:0]     sel_width;

    hm_sync #(.N(NCH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ch_req),
        .sync_out (sreq)
    );

    // Only channels whose request has been low since their last grant may
    // enter a snapshot.
    assign avail    = sreq & ok_q;
    assign pick_src = (state_q == ST_IDLE) ? avail : queue_q;

    hm_prio #(.N(NCH), .IDW(CHW)) u_prio (
        .vec    (pick_src),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    // Select the granted channel's time record.
    always_comb begin
        sel_lead  = '0;
        sel_trail = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pick_oh[i]) begin
                sel_lead  = ch_lead[i*TW +: TW];
                sel_trail = ch_trail[i*TW +: TW];
            end
        end
    end

    hm_width #(.TW(TW)) u_width (
        .lead  (sel_lead),
        .trail (sel_trail),
        .roll  (roll_max),
        .sel   (wsel),
        .width (sel_width)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        queue_d = queue_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin
                    queue_d = avail & ~pick_oh;
                    state_d = (queue_d != '0) ? ST_SERVE : ST_IDLE;
                end
            end
            ST_SERVE: begin
                queue_d = queue_q & ~pick_oh;
                state_d = (queue_d != '0) ? ST_SERVE : ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                queue_d = '0;
            end
        endcase
    end

    // Per-channel eligibility mask.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ok
            assign ok_d[g] = !sreq[g] || (ok_q[g] && !pick_oh[g]);
        end
    endgenerate

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            queue_q <= '0;
            ok_q    <= '1;
        end else begin
            state_q <= state_d;
            queue_q <= queue_d;
            ok_q    <= ok_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt      <= '0;
            wr_en    <= 1'b0;
            wr_ch    <= '0;
            wr_lead  <= '0;
            wr_width <= '0;
        end else begin
            gnt   <= pick_oh;
            wr_en <= pick_found;
            if (pick_found) begin
                wr_ch    <= pick_idx;
                wr_lead  <= sel_lead;
                wr_width <= sel_width;
            end
        end
    end

    // Assertions.
    a_r5_grant_onehot: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(gnt)
    );

    a_r5_write_names_grant: assert property (
        @(posedge clk) disable iff (!rst_n) wr_en |-> gnt[wr_ch]
    );

    a_r4_queue_only_drains: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE) |=> ((queue_q & ~$past(queue_q)) == '0)
    );

    generate
        for (g = 0; g < NCH; g++) begin : g_chk
            a_r6_no_back_to_back: assert property (
                @(posedge clk) disable iff (!rst_n) gnt[g] |=> !gnt[g]
            );
        end
    endgenerate

endmodule

// File: tb/sim_hm_merge_arb.sv
module sim_hm_merge_arb;

    localparam int NCH = 24;
    localparam int TW  = 13;
    localparam int CHW = $clog2(NCH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ch_req = '0;
    logic [NCH*TW-1:0] ch_lead = '0;
    logic [NCH*TW-1:0] ch_trail = '0;
    logic [TW-1:0]     roll_max = 13'd4095;
    logic [2:0]        wsel = 3'd0;
    logic [NCH-1:0]    gnt;
    logic              wr_en;
    logic [CHW-1:0]    wr_ch;
    logic [TW-1:0]     wr_lead;
    logic [7:0]        wr_width;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int log_ch[0:63];
    int log_lead[0:63];
    int log_w[0:63];
    int nlog;

    hm_merge_arb #(.NCH(NCH), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_lead(ch_lead),
        .ch_trail(ch_trail), .roll_max(roll_max), .wsel(wsel), .gnt(gnt),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_lead(wr_lead), .wr_width(wr_width)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog actual=%0d expected<=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_width(input int lead, input int trail, input int roll, input int sel);
        int raw;
        raw = (trail >= lead) ? trail - lead : trail + roll + 1 - lead;
        raw = raw >> sel;
        return (raw > 255) ? 255 : raw;
    endfunction

    task automatic set_ch(input int ch, input int lead, input int trail);
        ch_lead[ch*TW +: TW]  = TW'(lead);
        ch_trail[ch*TW +: TW] = TW'(trail);
    endtask

    // Runs n cycles, logging writes; the channel model drops a request on grant unless hold is set.
    task automatic collect(input int n, input bit hold);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (wr_en) begin
                chk(gnt[wr_ch] == 1'b1, "R5 grant with write", int'(gnt[wr_ch]), 1);
                chk($countones(gnt) == 1, "R5 single grant", $countones(gnt), 1);
                if (nlog < 64) begin
                    log_ch[nlog]   = int'(wr_ch);
                    log_lead[nlog] = int'(wr_lead);
                    log_w[nlog]    = int'(wr_width);
                end
                nlog++;
                if (!hold) ch_req[wr_ch] = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(gnt == '0, "R1 gnt at reset", int'(gnt), 0);
        chk(wr_en == 1'b0, "R1 wr_en at reset", int'(wr_en), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R1 idle after reset", int'(wr_en), 0);
    endtask

    task automatic t_latency();
        set_ch(4, 321, 330);
        wsel = 3'd0;
        @(negedge clk);
        ch_req[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(wr_en == 1'b0, "R2 no write after two edges", int'(wr_en), 0);
        @(negedge clk);
        chk(wr_en == 1'b1, "R2 write after third edge", int'(wr_en), 1);
        chk(int'(wr_ch) == 4, "R7 channel id", int'(wr_ch), 4);
        chk(int'(wr_lead) == 321, "R7 lead time", int'(wr_lead), 321);
        chk(int'(wr_width) == 9, "R8 plain width", int'(wr_width), 9);
        ch_req[4] = 1'b0;
        nlog = 0;
        collect(8, 1'b0);
        chk(nlog == 0, "R6 no second write", nlog, 0);
    endtask

    task automatic one_width(input int lead, input int trail, input int roll, input int sel, input string tag);
        int e;
        set_ch(9, lead, trail);
        roll_max = TW'(roll);
        wsel = 3'(sel);
        e = exp_width(lead, trail, roll, sel);
        nlog = 0;
        @(negedge clk);
        ch_req[9] = 1'b1;
        collect(10, 1'b0);
        chk(nlog == 1, {tag, " write count"}, nlog, 1);
        chk(log_w[0] == e, tag, log_w[0], e);
        chk(log_lead[0] == lead, "R7 lead passthrough", log_lead[0], lead);
    endtask

    task automatic t_widths();
        one_width(100, 150, 4095, 0, "R8 width no wrap");
        one_width(3550, 20, 3563, 0, "R8 width wrap roll");
        one_width(4000, 10, 4095, 0, "R8 width wrap full");
        one_width(0, 1000, 4095, 0, "R10 saturate sel0");
        one_width(0, 1000, 4095, 1, "R10 saturate sel1");
        one_width(0, 1000, 4095, 2, "R9 sel2");
        one_width(0, 1000, 4095, 4, "R9 sel4");
        one_width(0, 1000, 4095, 7, "R9 sel7");
        one_width(0, 4095, 4095, 3, "R10 saturate sel3");
    endtask

    task automatic t_priority();
        int exp_ord[5] = '{0, 2, 5, 20, 23};
        wsel = 3'd0;
        roll_max = 13'd4095;
        foreach (exp_ord[i]) set_ch(exp_ord[i], exp_ord[i] * 10, exp_ord[i] * 10 + 3);
        nlog = 0;
        @(negedge clk);
        ch_req[5] = 1'b1; ch_req[2] = 1'b1; ch_req[20] = 1'b1;
        ch_req[23] = 1'b1; ch_req[0] = 1'b1;
        collect(15, 1'b0);
        chk(nlog == 5, "R3 write count", nlog, 5);
        for (int i = 0; i < 5; i++) begin
            chk(log_ch[i] == exp_ord[i], "R3 ascending order", log_ch[i], exp_ord[i]);
        end
    endtask

    task automatic t_fairness();
        nlog = 0;
        @(negedge clk);
        for (int c = 10; c < 18; c++) ch_req[c] = 1'b1;
        while (nlog == 0) collect(1, 1'b0);
        ch_req[0] = 1'b1;
        collect(25, 1'b0);
        chk(nlog == 9, "R4 write count", nlog, 9);
        for (int i = 0; i < 8; i++) begin
            chk(log_ch[i] == 10 + i, "R4 snapshot served first", log_ch[i], 10 + i);
        end
        chk(log_ch[8] == 0, "R4 late arrival last", log_ch[8], 0);
    endtask

    task automatic t_hold();
        nlog = 0;
        @(negedge clk);
        ch_req[7] = 1'b1;
        collect(20, 1'b1);
        chk(nlog == 1, "R6 held request served once", nlog, 1);
        ch_req[7] = 1'b0;
        collect(6, 1'b0);
        nlog = 0;
        ch_req[7] = 1'b1;
        collect(8, 1'b0);
        chk(nlog == 1, "R6 eligible after low", nlog, 1);
    endtask

    initial begin
        nlog = 0;
        t_reset();
        t_latency();
        t_widths();
        t_priority();
        t_fairness();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule